// File: doc/BRIEF.md
# Recursive Carry-Lookahead Adder

This block is a purely combinational, parameterised adder of two WIDTH-bit unsigned words. Its typical job is the last step of a multiplier: turning the two rows left by a carry-save reduction into one binary word. It first forms a generate/propagate pair for each bit position. It then finds the carry into every position with a tree that splits each span of bits in two. The lower half of a span gets the rounded-up share of the bits and receives the span's incoming carry. The carry into the upper half is evaluated from the lower half's group signals.

The incoming carry at bit zero is tied low. The carry out of the top bit is never formed, so the result is the sum modulo 2^WIDTH. The block holds no state. No clock or reset reaches it, and an output is valid as soon as its operands have settled.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals (`opd_a` + `opd_b`) mod 2^WIDTH for every pair of operands.
- R2: The carry into bit 0 is zero. Adding an all-zero operand returns the other operand unchanged, and 0 + 0 gives 0.
- R3: The carry out of the top bit is dropped. All ones plus one gives zero, with no wider result.
- R4: When every position only propagates (`opd_a` XOR `opd_b` is all ones), the result is all ones, because no carry is ever started.
- R5: A carry generated at any bit k, where both operands have bit k set, travels through a run of propagating positions above it up to the top bit. With `opd_a` = ones at bits k and above and `opd_b` = 1<<k, the result is zero.
- R6: The result does not depend on the order of the operands: a + b equals b + a.
- R7: Every result is due in the same time step as its operands, with no clock edge in between.
- R8: The structure is correct for any WIDTH from 1 up, including odd widths where the halves differ in size (widths 1, 3, 5, 8, 32 and 61 are exercised).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First addend |
| opd_b | input | WIDTH | Second addend |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |

## Verification
The results take zero cycles: every sum is due in the same time step as the operands that produce it. The bench drives all six widths from one shared operand bus and waits one nanosecond for the logic to settle. It then samples each sum before the operands change again, so no check depends on a clock edge. Widths up to 8 are covered exhaustively, and the wide instances get seeded random words together with directed carry-chain patterns.

// File: rtl/la_pkg.sv
package la_pkg;

  // Generate/propagate pair of one bit or one group of bits.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine a lower group with the group directly above it.
  function automatic gp_t gp_join(gp_t lo, gp_t hi);
    gp_t r;
    r.g = hi.g | (lo.g & hi.p);
    r.p = lo.p & hi.p;
    return r;
  endfunction

  // Carry leaving a group, given the carry entering it.
  function automatic logic gp_carry(gp_t grp, logic cin);
    return grp.g | (grp.p & cin);
  endfunction

endpackage

// File: rtl/la_bit_cell.sv
module la_bit_cell (
  input  logic         a_i,
  input  logic         b_i,
  output la_pkg::gp_t  gp_o
);

  always_comb begin
    gp_o.g = a_i & b_i;
    gp_o.p = a_i ^ b_i;
  end

endmodule

// File: rtl/la_carry_tree.sv
module la_carry_tree #(
  parameter int W = 4
) (
  input  la_pkg::gp_t [W-1:0] bit_gp_i,
  input  logic                cin_i,
  output la_pkg::gp_t         grp_o,
  output logic [W-1:0]        carry_o
);

  generate
    if (W == 1) begin : g_leaf
      assign grp_o      = bit_gp_i[0];
      assign carry_o[0] = cin_i;
    end else begin : g_split
      // Lower half takes the rounded-up share of the span.
      localparam int LO = (W + 1) / 2;
      localparam int HI = W - LO;

      la_pkg::gp_t        lo_grp;
      la_pkg::gp_t        hi_grp;
      logic               mid_carry;
      logic [LO-1:0]      lo_carry;
      logic [HI-1:0]      hi_carry;

      la_carry_tree #(.W(LO)) u_lo (
        .bit_gp_i (bit_gp_i[LO-1:0]),
        .cin_i    (cin_i),
        .grp_o    (lo_grp),
        .carry_o  (lo_carry)
      );

      assign mid_carry = la_pkg::gp_carry(lo_grp, cin_i);

      la_carry_tree #(.W(HI)) u_hi (
        .bit_gp_i (bit_gp_i[W-1:LO]),
        .cin_i    (mid_carry),
        .grp_o    (hi_grp),
        .carry_o  (hi_carry)
      );

      assign grp_o   = la_pkg::gp_join(lo_grp, hi_grp);
      assign carry_o = {hi_carry, lo_carry};
    end
  endgenerate

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opd_a,
  input  logic [WIDTH-1:0] opd_b,
  output logic [WIDTH-1:0] sum_o
);

  la_pkg::gp_t [WIDTH-1:0] bit_gp;
  la_pkg::gp_t             unused_root_grp;
  logic [WIDTH-1:0]        carry_in;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_cell
      la_bit_cell u_cell (
        .a_i  (opd_a[i]),
        .b_i  (opd_b[i]),
        .gp_o (bit_gp[i])
      );
    end
  endgenerate

  // Carry into bit 0 is tied low; root group carry-out is discarded.
  la_carry_tree #(.W(WIDTH)) u_tree (
    .bit_gp_i (bit_gp),
    .cin_i    (1'b0),
    .grp_o    (unused_root_grp),
    .carry_o  (carry_in)
  );

  generate
    for (i = 0; i < WIDTH; i++) begin : g_sum
      assign sum_o[i] = bit_gp[i].p ^ carry_in[i];
    end
  endgenerate

endmodule

// File: rtl/lookahead_adder_chk.sv
module lookahead_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opd_a,
  input logic [WIDTH-1:0] opd_b,
  input logic [WIDTH-1:0] sum_o
);

  logic [WIDTH-1:0] one_w;
  assign one_w = WIDTH'(1);

  always_comb begin
    // R1: arithmetic reference sum, truncated to the word.
    a_r1_mod_sum: assert (sum_o == WIDTH'(opd_a + opd_b));
    // R2: zero addend leaves the other operand untouched.
    if (opd_b == '0) begin
      a_r2_zero_addend: assert (sum_o == opd_a);
    end
    // R3: all ones plus one wraps to zero.
    if (opd_a == '1 && opd_b == one_w) begin
      a_r3_no_overflow: assert (sum_o == '0);
    end
    // R4: full propagate run without generate gives all ones.
    if ((opd_a ^ opd_b) == '1) begin
      a_r4_full_propagate: assert (sum_o == '1);
    end
  end

endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .opd_a (opd_a),
  .opd_b (opd_b),
  .sum_o (sum_o)
);

// File: tb/lookahead_adder_tb.sv
`timescale 1ns/1ps
module lookahead_adder_tb;

  logic clk;
  logic [63:0] a_bus;
  logic [63:0] b_bus;
  int n_chk;
  int n_bad;
  int cyc;

  logic [0:0]  s1;
  logic [2:0]  s3;
  logic [4:0]  s5;
  logic [7:0]  s8;
  logic [31:0] s32;
  logic [60:0] s61;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  lookahead_adder #(.WIDTH(1))  u_dut_w1  (.opd_a(a_bus[0:0]),  .opd_b(b_bus[0:0]),  .sum_o(s1));
  lookahead_adder #(.WIDTH(3))  u_dut_w3  (.opd_a(a_bus[2:0]),  .opd_b(b_bus[2:0]),  .sum_o(s3));
  lookahead_adder #(.WIDTH(5))  u_dut_w5  (.opd_a(a_bus[4:0]),  .opd_b(b_bus[4:0]),  .sum_o(s5));
  lookahead_adder #(.WIDTH(8))  u_dut_w8  (.opd_a(a_bus[7:0]),  .opd_b(b_bus[7:0]),  .sum_o(s8));
  lookahead_adder               u_dut     (.opd_a(a_bus[31:0]), .opd_b(b_bus[31:0]), .sum_o(s32));
  lookahead_adder #(.WIDTH(61)) u_dut_w61 (.opd_a(a_bus[60:0]), .opd_b(b_bus[60:0]), .sum_o(s61));

  function automatic logic [63:0] wmask(int w);
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic logic [63:0] ref_sum(logic [63:0] a, logic [63:0] b, int w);
    return (a + b) & wmask(w);
  endfunction

  function automatic logic [63:0] dut_sum(int w);
    case (w)
      1:  return {63'd0, s1};
      3:  return {61'd0, s3};
      5:  return {59'd0, s5};
      8:  return {56'd0, s8};
      32: return {32'd0, s32};
      default: return {3'd0, s61};
    endcase
  endfunction

  task automatic cmp(string req, int w, logic [63:0] exp);
    logic [63:0] got;
    got = dut_sum(w);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s width=%0d a=%h b=%h got=%h exp=%h", req, w,
               a_bus & wmask(w), b_bus & wmask(w), got, exp);
    end
  endtask

  // R7: sample one ns after driving, with no clock edge involved.
  task automatic apply(logic [63:0] a, logic [63:0] b, string req);
    int ws[6] = '{1, 3, 5, 8, 32, 61};
    a_bus = a;
    b_bus = b;
    #1;
    foreach (ws[k]) cmp(req, ws[k], ref_sum(a, b, ws[k]));
  endtask

  task automatic apply_exp(logic [63:0] a, logic [63:0] b, int w, logic [63:0] exp, string req);
    a_bus = a;
    b_bus = b;
    #1;
    cmp(req, w, exp);
  endtask

  initial begin
    int wd[6] = '{1, 3, 5, 8, 32, 61};
    logic [63:0] ra;
    logic [63:0] rb;
    int seed_dummy;
    n_chk = 0;
    n_bad = 0;
    a_bus = '0;
    b_bus = '0;
    seed_dummy = $urandom(32'h1bad5eed);

    // R2: zero operands give zero (idle state of the block).
    foreach (wd[k]) apply_exp(64'd0, 64'd0, wd[k], 64'd0, "R2");

    // R1 / R8: exhaustive for widths up to 8.
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        apply(64'(x), 64'(y), "R1_R8");
      end
    end

    foreach (wd[k]) begin
      // R2: zero addend returns the other operand.
      apply_exp(64'h0123_4567_89ab_cdef, 64'd0, wd[k], 64'h0123_4567_89ab_cdef & wmask(wd[k]), "R2");
      // R3: all ones plus one wraps to zero.
      apply_exp(wmask(wd[k]), 64'd1, wd[k], 64'd0, "R3");
      // R4: pure propagate gives all ones.
      apply_exp(64'h5555_5555_5555_5555 & wmask(wd[k]), 64'haaaa_aaaa_aaaa_aaaa & wmask(wd[k]),
                wd[k], wmask(wd[k]), "R4");
      // R5: carry generated at bit k runs to the top and out.
      for (int j = 0; j < wd[k]; j++) begin
        apply_exp(wmask(wd[k]) & ~wmask(j), 64'd1 << j, wd[k], 64'd0, "R5");
      end
    end

    // R1 / R6: random wide operands, both orders.
    for (int r = 0; r < 3000; r++) begin
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      apply(ra, rb, "R1");
      apply(rb, ra, "R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // Watchdog: an overlong run counts as a failed check.
  initial cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got cycle=%0d exp below 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule